// File: doc/BRIEF.md
# Delayed Interrupt Coalescing Unit

This block merges per-ring completion pulses from four receive rings and four transmit rings into two interrupt requests, group A and group B. Each group is programmed by its own 32-bit configuration word. The word chooses which rings feed the group, sets an event-count threshold, and sets a maximum delay. The delay is measured in ticks of an external timebase, one tick per 10 µs. A group raises its request on whichever comes first: enough pending events, or the delay running out after the first pending event.

A group's request stays high until software acknowledges that group. The acknowledge starts a fresh interval. Events that land in the same cycle as the acknowledge already count toward the new interval. The two groups share only the event inputs and the timebase, and otherwise run independently.

Top module: `irq_coalesce`

## Requirements
- R1: Configuration word layout. Bit 28+i enables receive ring i and bit 24+i enables transmit ring i, for i = 0..3. Bits 20:16 hold the event threshold and bits 10:0 hold the maximum delay in ticks. All other bits are ignored.
- R2: An event pulse from a ring that is not enabled in a group's word has no effect on that group's request, count or timer.
- R3: Events from several enabled rings in the same cycle each add one to the group's pending count.
- R4: With a non-zero threshold, the request is high from the cycle after the pending count first reaches the threshold.
- R5: The delay timer starts at the first pending event of an interval. It advances once per tick and is not restarted by later events. With a non-zero delay, the request is high from the cycle after the tick that brings the timer to the delay value.
- R6: A threshold of 0 disables the count trigger and a delay of 0 disables the timer trigger. When both are 0, any enabled event raises the request in the next cycle.
- R7: The request stays high until the group's acknowledge. The acknowledge clears the pending count and the timer. Events in the acknowledge cycle count toward the next interval and may raise the request again in the next cycle.
- R8: Acknowledging or reconfiguring one group does not alter the other group's request.
- R9: The largest threshold (31) and the largest delay (2047) can both be reached. The pending count saturates instead of wrapping.
- R10: While reset is asserted and right after it is released, both requests are low and counts and timers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse, one per 10 µs |
| rx_evt | input | 4 | Receive ring completion pulses, bit i = ring i |
| tx_evt | input | 4 | Transmit ring completion pulses, bit i = ring i |
| cfg_a | input | 32 | Group A configuration word |
| cfg_b | input | 32 | Group B configuration word |
| ack_a | input | 1 | Group A acknowledge pulse |
| ack_b | input | 1 | Group B acknowledge pulse |
| irq_a | output | 1 | Group A interrupt request |
| irq_b | output | 1 | Group B interrupt request |

## Verification
The pending count and the timer are hidden, so errors in them surface only as an early or late edge on a request. A count that is off by one, or that wrapped, moves the count-triggered edge by a cycle or hides it entirely. A timer that restarted, or missed a tick, shifts the timeout edge by at least one tick. The bench therefore checks each request in the exact cycle its edge is due, and again in the cycle just before. A state that is not cleared on acknowledge shows up within one cycle as a request that rises again without new events.

// File: rtl/coal_pkg.sv
package coal_pkg;
   // Default geometry of the configuration word
   localparam int unsigned RING_CNT  = 4;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned LIMIT_W   = 5;
   localparam int unsigned WAIT_W    = 11;
   localparam int unsigned RX_EN_LSB = 28;
   localparam int unsigned TX_EN_LSB = 24;
   localparam int unsigned LIMIT_LSB = 16;
   localparam int unsigned WAIT_LSB  = 0;

   // Width needed to hold a count of 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/coal_cfg_decode.sv
module coal_cfg_decode
   import coal_pkg::*;
#(
   parameter int unsigned RINGS   = RING_CNT,
   parameter int unsigned CFG_W   = WORD_W,
   parameter int unsigned THR_W   = LIMIT_W,
   parameter int unsigned DLY_W   = WAIT_W,
   parameter int unsigned RX_LSB  = RX_EN_LSB,
   parameter int unsigned TX_LSB  = TX_EN_LSB,
   parameter int unsigned THR_LSB = LIMIT_LSB,
   parameter int unsigned DLY_LSB = WAIT_LSB
) (
   input  logic [CFG_W-1:0]   cfg,
   output logic [2*RINGS-1:0] src_en,
   output logic [THR_W-1:0]   thr,
   output logic [DLY_W-1:0]   dly
);
   // Elaboration-time checks on the field layout
   if (RX_LSB + RINGS > CFG_W) begin : g_bad_rx
      $error("receive enable field exceeds word");
   end
   if (TX_LSB + RINGS > CFG_W) begin : g_bad_tx
      $error("transmit enable field exceeds word");
   end
   if (THR_LSB + THR_W > CFG_W) begin : g_bad_thr
      $error("threshold field exceeds word");
   end
   if (DLY_LSB + DLY_W > CFG_W) begin : g_bad_dly
      $error("delay field exceeds word");
   end

   // Low half of src_en = receive rings, high half = transmit rings
   assign src_en = {cfg[TX_LSB +: RINGS], cfg[RX_LSB +: RINGS]};
   assign thr    = cfg[THR_LSB +: THR_W];
   assign dly    = cfg[DLY_LSB +: DLY_W];
endmodule

// File: rtl/coal_evt_sum.sv
module coal_evt_sum #(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned SUM_W = 4
) (
   input  logic [N_IN-1:0]  evt,
   input  logic [N_IN-1:0]  en,
   output logic [SUM_W-1:0] cnt
);
   if (SUM_W < $clog2(N_IN + 1)) begin : g_bad_w
      $error("sum width too small for input count");
   end

   logic [N_IN-1:0] hit;
   assign hit = evt & en;

   if (N_IN == 1) begin : g_single
      assign cnt = SUM_W'(hit[0]);
   end else begin : g_multi
      always_comb begin
         cnt = '0;
         for (int i = 0; i < N_IN; i++) begin
            cnt = cnt + SUM_W'(hit[i]);
         end
      end
   end

   // R2 / R3: never more counted than enabled sources present
   always_comb begin
      p_sum_bound_r3 : assert (32'(cnt) <= 32'($countones(en)));
      p_masked_zero_r2 : assert ((en != '0) || (cnt == '0));
   end
endmodule

// File: rtl/coal_group.sv
module coal_group #(
   parameter int unsigned THR_W = 5,
   parameter int unsigned DLY_W = 11,
   parameter int unsigned SUM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ack,
   input  logic [SUM_W-1:0] inc,
   input  logic [THR_W-1:0] thr,
   input  logic [DLY_W-1:0] dly,
   output logic             irq
);
   localparam int unsigned ACC_W = ((THR_W > SUM_W) ? THR_W : SUM_W) + 1;
   localparam logic [THR_W-1:0] CNT_MAX = '1;
   localparam logic [DLY_W-1:0] TMR_MAX = '1;

   logic [THR_W-1:0] pend_q, pend_d;
   logic [DLY_W-1:0] tmr_q, tmr_d;
   logic             run_q, run_d;
   logic             irq_q, irq_d;
   logic [ACC_W-1:0] acc;
   logic             has_evt, fire_cnt, fire_tmr, fire_now;

   always_comb begin
      has_evt = (inc != '0);
      // Acknowledge opens a new interval; same-cycle events belong to it
      acc     = (ack ? '0 : ACC_W'(pend_q)) + ACC_W'(inc);
      pend_d  = (acc > ACC_W'(CNT_MAX)) ? CNT_MAX : acc[THR_W-1:0];
      run_d   = ack ? has_evt : (run_q | has_evt);
      tmr_d   = tmr_q;
      if (ack) begin
         tmr_d = '0;
      end else if (run_q && tick && !irq_q && (tmr_q != TMR_MAX)) begin
         tmr_d = tmr_q + DLY_W'(1);
      end
      fire_cnt = (thr != '0) && (pend_d >= thr);
      fire_tmr = (dly != '0) && run_q && !ack && (tmr_d >= dly);
      fire_now = (thr == '0) && (dly == '0) && has_evt;
      irq_d    = (irq_q & ~ack) | fire_cnt | fire_tmr | fire_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         tmr_q  <= '0;
         run_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         tmr_q  <= tmr_d;
         run_q  <= run_d;
         irq_q  <= irq_d;
      end
   end

   assign irq = irq_q;

   // R7: request held until acknowledged
   p_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q && !ack |=> irq_q);
   // R7: a quiet acknowledge leaves a clean interval
   p_ack_clear_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ack && !has_evt |=> !irq_q && (pend_q == '0) && (tmr_q == '0));
   // R9: saturated count never wraps
   p_no_overflow_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == CNT_MAX) && !ack |=> pend_q == CNT_MAX);
   // R5: timer only moves forward within an interval
   p_tmr_mono_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> tmr_q >= $past(tmr_q));
   // R5: timer frozen while no event is pending
   p_tmr_idle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !run_q && !ack |=> tmr_q == $past(tmr_q));
   // R6: with both triggers off, only an event can raise the request
   p_imm_only_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (thr == '0) && (dly == '0) && !irq_q && !has_evt |=> !irq_q);
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
   import coal_pkg::*;
#(
   parameter int unsigned RINGS   = RING_CNT,
   parameter int unsigned CFG_W   = WORD_W,
   parameter int unsigned THR_W   = LIMIT_W,
   parameter int unsigned DLY_W   = WAIT_W,
   parameter int unsigned RX_LSB  = RX_EN_LSB,
   parameter int unsigned TX_LSB  = TX_EN_LSB,
   parameter int unsigned THR_LSB = LIMIT_LSB,
   parameter int unsigned DLY_LSB = WAIT_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [RINGS-1:0] rx_evt,
   input  logic [RINGS-1:0] tx_evt,
   input  logic [CFG_W-1:0] cfg_a,
   input  logic [CFG_W-1:0] cfg_b,
   input  logic             ack_a,
   input  logic             ack_b,
   output logic             irq_a,
   output logic             irq_b
);
   localparam int unsigned N_SRC   = 2 * RINGS;
   localparam int unsigned SUM_W   = cnt_width(N_SRC);
   localparam int unsigned N_GROUP = 2;

   if (RINGS < 1) begin : g_bad_rings
      $error("at least one ring per direction required");
   end

   logic [N_SRC-1:0] evt_all;
   logic [CFG_W-1:0] cfg_g [N_GROUP];
   logic [N_GROUP-1:0] ack_g, irq_g;

   assign evt_all  = {tx_evt, rx_evt};
   assign cfg_g[0] = cfg_a;
   assign cfg_g[1] = cfg_b;
   assign ack_g    = {ack_b, ack_a};

   for (genvar g = 0; g < N_GROUP; g++) begin : g_grp
      logic [N_SRC-1:0] src_en;
      logic [THR_W-1:0] thr;
      logic [DLY_W-1:0] dly;
      logic [SUM_W-1:0] inc;

      coal_cfg_decode #(
         .RINGS(RINGS), .CFG_W(CFG_W), .THR_W(THR_W), .DLY_W(DLY_W),
         .RX_LSB(RX_LSB), .TX_LSB(TX_LSB), .THR_LSB(THR_LSB), .DLY_LSB(DLY_LSB)
      ) u_dec (
         .cfg(cfg_g[g]), .src_en(src_en), .thr(thr), .dly(dly)
      );

      coal_evt_sum #(.N_IN(N_SRC), .SUM_W(SUM_W)) u_sum (
         .evt(evt_all), .en(src_en), .cnt(inc)
      );

      coal_group #(.THR_W(THR_W), .DLY_W(DLY_W), .SUM_W(SUM_W)) u_grp (
         .clk(clk), .rst_n(rst_n), .tick(tick), .ack(ack_g[g]),
         .inc(inc), .thr(thr), .dly(dly), .irq(irq_g[g])
      );
   end

   assign irq_a = irq_g[0];
   assign irq_b = irq_g[1];

   // R8: acknowledging A alone never drops B's request
   p_group_indep_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_a && !ack_b && irq_b |=> irq_b);
   // R8: acknowledging B alone never drops A's request
   p_group_indep_b_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_b && !ack_a && irq_a |=> irq_a);
endmodule

// File: tb/irq_coalesce_bench.sv
module irq_coalesce_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [3:0]  rx_evt = '0;
   logic [3:0]  tx_evt = '0;
   logic [31:0] cfg_a = '0;
   logic [31:0] cfg_b = '0;
   logic        ack_a = 1'b0;
   logic        ack_b = 1'b0;
   logic        irq_a, irq_b;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   irq_coalesce u_irq_coalesce (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_evt(rx_evt), .tx_evt(tx_evt),
      .cfg_a(cfg_a), .cfg_b(cfg_b), .ack_a(ack_a), .ack_b(ack_b),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   // {rx[3:0], tx[3:0], tick, ack_a, expected irq_a, expected irq_b}
   // cfg_a = rx rings 0,2 + tx rings 0,1, threshold 3, delay 2
   // cfg_b = all rx rings, threshold 0, delay 0
   localparam logic [11:0] VEC [16] = '{
      12'b0001_0000_0_0_0_1,   // enabled rx0: count 1
      12'b0010_0000_0_0_0_1,   // rx1 masked in A
      12'b0000_0000_1_0_0_1,   // timer 1
      12'b0100_0001_0_0_1_1,   // two at once: count 3 -> fire
      12'b0000_0000_0_0_1_1,   // held
      12'b0000_0000_0_1_0_1,   // acknowledge
      12'b0000_0000_1_0_0_1,   // tick while idle
      12'b0000_0010_0_0_0_1,   // tx1: count 1, timer starts
      12'b0000_0000_1_0_0_1,   // timer 1
      12'b0000_0000_1_0_1_1,   // timer 2 -> timeout
      12'b0001_0000_0_1_0_1,   // ack with event: count 1 next interval
      12'b0000_0000_1_0_0_1,   // timer 1
      12'b1000_1100_0_0_0_1,   // masked rings only
      12'b0101_0000_0_0_1_1,   // count 3 -> fire
      12'b0101_0011_0_1_1_1,   // ack with four events -> refire
      12'b0000_0000_0_1_0_1    // quiet ack
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic [3:0] r, input logic [3:0] t, input logic tk,
                      input logic aa, input logic ab);
      rx_evt = r; tx_evt = t; tick = tk; ack_a = aa; ack_b = ab;
      @(posedge clk);
      #1;
      rx_evt = '0; tx_evt = '0; tick = 1'b0; ack_a = 1'b0; ack_b = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R10: reset holds requests low even with events present
      cfg_a = 32'h5303_0002;
      cfg_b = 32'hF000_0000;
      rx_evt = 4'hF; tx_evt = 4'hF;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset irq_a", irq_a, 1'b0);
      chk("R10 reset irq_b", irq_b, 1'b0);
      rx_evt = '0; tx_evt = '0;
      rst_n = 1'b1;
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R10 after release irq_a", irq_a, 1'b0);
      chk("R10 after release irq_b", irq_b, 1'b0);

      // R1 R2 R3 R4 R5 R6 R7 R8: vector walk
      for (int i = 0; i < 16; i++) begin
         cyc(VEC[i][11:8], VEC[i][7:4], VEC[i][3], VEC[i][2], 1'b0);
         chk($sformatf("R1/R4/R5/R7 vec %0d irq_a", i), irq_a, VEC[i][1]);
         chk($sformatf("R6/R8 vec %0d irq_b", i), irq_b, VEC[i][0]);
      end

      // R5: later events do not restart the timer (delay 3, rx0)
      cfg_a = 32'h1000_0003;
      cyc(4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
      cyc(4'h1, 4'h0, 1'b0, 1'b0, 1'b0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      cyc(4'h1, 4'h0, 1'b0, 1'b0, 1'b0);
      chk("R5 before third tick", irq_a, 1'b0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R5 third tick no restart", irq_a, 1'b1);

      // R7: acknowledge clears a partial count (threshold 2)
      cfg_a = 32'h1002_0000;
      cyc(4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
      cyc(4'h1, 4'h0, 1'b0, 1'b0, 1'b0);
      cyc(4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
      cyc(4'h1, 4'h0, 1'b0, 1'b0, 1'b0);
      chk("R7 count cleared by ack", irq_a, 1'b0);
      cyc(4'h1, 4'h0, 1'b0, 1'b0, 1'b0);
      chk("R4 threshold 2 reached", irq_a, 1'b1);

      // R6: zero delay disables the timeout (threshold 5)
      cfg_a = 32'h1005_0000;
      cyc(4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
      cyc(4'h1, 4'h0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 20; k++) cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R6 no timeout with delay 0", irq_a, 1'b0);

      // R9: threshold 31 with saturating count, all sources enabled
      cfg_a = 32'hFF1F_0000;
      cyc(4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) cyc(4'hF, 4'hF, 1'b0, 1'b0, 1'b0);
      chk("R9 24 events below 31", irq_a, 1'b0);
      cyc(4'hF, 4'hF, 1'b0, 1'b0, 1'b0);
      chk("R9 threshold 31 reached", irq_a, 1'b1);

      // R9: largest delay 2047
      cfg_a = 32'h1000_07FF;
      cyc(4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
      cyc(4'h1, 4'h0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 2046; k++) cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R9 tick 2046 early", irq_a, 1'b0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R9 delay 2047 reached", irq_a, 1'b1);

      // R8: B untouched by all of A's traffic, then cleared by its own ack
      chk("R8 irq_b kept", irq_b, 1'b1);
      cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
      chk("R8 irq_b acked", irq_b, 1'b0);
      chk("R8 irq_a unaffected by ack_b", irq_a, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule